// File: doc/BRIEF.md
# Branch Status Tagging Injector

This block sits on a 16-byte instruction line path that is used during self-test. Each accepted line is passed through unchanged. Alongside it the block produces a 3-bit status code for every byte position. In test mode it searches each line for bytes that match a branch opcode pattern. The leftmost matching byte is marked as a two-byte branch. The byte positions that follow it are marked unused. The window stays open into the next accepted line: that line is marked unused up to the same byte position, and that position is marked as the branch target.

Outside test mode every status code stays at the non-branch default, and no window is opened. Only one window can be open at a time. A match in a line that closes a window does not start a new one. The block has a valid/ready handshake on both sides and a single register stage, so a line leaves one cycle after it is accepted.

Top module: `branch_tag_inject`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Byte i of a line is bits [8i+7:8i], and byte 0 is the leftmost. Status i is out_status[3i+2:3i]. The codes are 3'b000 none, 3'b001 branch, 3'b010 unused and 3'b100 target. With the default parameters, a byte matches when (byte & 8'hF0) == 8'hE0.
- R3: If test_en is low when a line is accepted, every status field of that line is none. Whenever test_en is low, any open window is abandoned.
- R4: In test mode, with no window open, only the leftmost matching byte k is marked branch. Every byte after k in that line is marked unused, including bytes that also match. Every byte before k is none.
- R5: The next line accepted in test mode after a branch at k has positions 0..k-1 marked unused, position k marked target, and positions above k marked none.
- R6: In a line that closes a window, matching bytes are ignored. No branch is marked, and the line after it carries no target.
- R7: A branch at position 15 marks no unused bytes in its own line. The next line gets unused at 0..14 and target at 15. A branch at position 0 causes only a target at position 0 in the next line.
- R8: in_ready equals !out_valid || out_ready. An accepted line is presented on the output in the next cycle. The output holds stable while out_valid is high and out_ready is low.
- R9: out_line equals the accepted in_line bit for bit, and lines leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Enables status marking |
| in_valid | input | 1 | Input line is valid |
| in_ready | output | 1 | Block can accept a line |
| in_line | input | 128 | Input instruction line, 16 bytes |
| out_valid | output | 1 | Output line is valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_line | output | 128 | Line passed through |
| out_status | output | 48 | Sixteen 3-bit status codes |

## Verification
The hardest case to reach is a window that spans two lines while the output is stalled, or while test mode drops between the branch line and the line that follows it. It is hard because the marking depends on which line is the next one accepted, not on the next cycle. The stimulus first sweeps the branch position over all sixteen bytes, with extra matches placed after the branch and in the closing line. It then runs a long random stream with random backpressure and occasional test-mode drops. A model in the bench tracks the window per accepted line.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef logic [2:0] tag_t;
  localparam tag_t TAG_NONE   = 3'b000;
  localparam tag_t TAG_BRANCH = 3'b001;
  localparam tag_t TAG_UNUSED = 3'b010;
  localparam tag_t TAG_TARGET = 3'b100;
endpackage

// File: rtl/bst_byte_match.sv
module bst_byte_match #(
  parameter int NBYTES = 16,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] MATCH = 8'hE0,
  parameter logic [BYTE_W-1:0] MASK  = 8'hF0
) (
  input  logic [NBYTES*BYTE_W-1:0] line,
  output logic [NBYTES-1:0]        hit
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign hit[i] = ((line[i*BYTE_W +: BYTE_W] & MASK) == (MATCH & MASK));
  end
endmodule

// File: rtl/bst_first_find.sv
module bst_first_find #(
  parameter int N     = 16,
  parameter int POS_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [POS_W-1:0] pos
);
  // lowest index wins: scan from the top so the last write is the lowest
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        pos   = POS_W'(i);
      end
    end
  end
endmodule

// File: rtl/bst_field_gen.sv
module bst_field_gen
  import bst_pkg::*;
#(
  parameter int N     = 16,
  parameter int POS_W = 4
) (
  input  logic             test_en,
  input  logic             pend,
  input  logic [POS_W-1:0] pend_pos,
  input  logic             found,
  input  logic [POS_W-1:0] br_pos,
  output logic [3*N-1:0]   status
);
  for (genvar i = 0; i < N; i++) begin : g_field
    tag_t code;
    always_comb begin
      code = TAG_NONE;
      if (test_en) begin
        if (pend) begin
          if (POS_W'(i) < pend_pos)       code = TAG_UNUSED;
          else if (POS_W'(i) == pend_pos) code = TAG_TARGET;
        end else if (found) begin
          if (POS_W'(i) == br_pos)        code = TAG_BRANCH;
          else if (POS_W'(i) > br_pos)    code = TAG_UNUSED;
        end
      end
    end
    assign status[3*i +: 3] = code;
  end
endmodule

// File: rtl/bst_out_stage.sv
module bst_out_stage #(
  parameter int W = 176
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;
  logic         load;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (load) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/branch_tag_inject.sv
module branch_tag_inject #(
  parameter int NBYTES = 16,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] MATCH = 8'hE0,
  parameter logic [BYTE_W-1:0] MASK  = 8'hF0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     test_en,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NBYTES*BYTE_W-1:0] in_line,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NBYTES*BYTE_W-1:0] out_line,
  output logic [3*NBYTES-1:0]      out_status
);
  localparam int LINE_W = NBYTES * BYTE_W;
  localparam int STAT_W = 3 * NBYTES;
  localparam int POS_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [NBYTES-1:0] hit;
  logic              found;
  logic [POS_W-1:0]  br_pos;
  logic [STAT_W-1:0] status;
  logic              accept;

  // open window across lines
  logic              pend_q, pend_d;
  logic [POS_W-1:0]  ppos_q, ppos_d;

  bst_byte_match #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .MATCH(MATCH), .MASK(MASK)) u_match (
    .line (in_line),
    .hit  (hit)
  );

  bst_first_find #(.N(NBYTES), .POS_W(POS_W)) u_find (
    .req   (hit),
    .found (found),
    .pos   (br_pos)
  );

  bst_field_gen #(.N(NBYTES), .POS_W(POS_W)) u_field (
    .test_en  (test_en),
    .pend     (pend_q),
    .pend_pos (ppos_q),
    .found    (found),
    .br_pos   (br_pos),
    .status   (status)
  );

  assign accept = in_valid && in_ready;

  always_comb begin
    pend_d = pend_q;
    ppos_d = ppos_q;
    if (!test_en) begin
      pend_d = 1'b0;
    end else if (accept) begin
      if (pend_q) begin
        pend_d = 1'b0;
      end else if (found) begin
        pend_d = 1'b1;
        ppos_d = br_pos;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ppos_q <= '0;
    end else begin
      pend_q <= pend_d;
      ppos_q <= ppos_d;
    end
  end

  bst_out_stage #(.W(LINE_W + STAT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({in_line, status}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  ({out_line, out_status})
  );
endmodule

// File: rtl/bst_chk.sv
module bst_chk #(
  parameter int NBYTES = 16,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     test_en,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [NBYTES*BYTE_W-1:0] in_line,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [NBYTES*BYTE_W-1:0] out_line,
  input logic [3*NBYTES-1:0]      out_status
);
  logic [NBYTES-1:0] br_bits, tg_bits, bad;

  always_comb begin
    for (int i = 0; i < NBYTES; i++) begin
      br_bits[i] = out_status[3*i];
      tg_bits[i] = out_status[3*i+2];
      bad[i]     = !$onehot0(out_status[3*i +: 3]);
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line) && $stable(out_status)));

  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R3
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !test_en) |=> (out_status == '0));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (bad == '0));

  // R4
  single_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(br_bits) <= 1 && $countones(tg_bits) <= 1));

  // R6
  branch_or_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((|br_bits) && (|tg_bits)));
endmodule

bind branch_tag_inject bst_chk #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .test_en    (test_en),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_line    (in_line),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_line   (out_line),
  .out_status (out_status)
);

// File: tb/branch_tag_inject_tb.sv
`timescale 1ns/1ps
module branch_tag_inject_tb;
  logic         clk;
  logic         rst_n;
  logic         test_en;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_line;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_line;
  logic [47:0]  out_status;

  branch_tag_inject u_dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_line(in_line),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_line(out_line), .out_status(out_status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 0;
  bit     bp_on = 0;

  // scoreboard
  logic [127:0] exp_line [0:1023];
  logic [47:0]  exp_stat [0:1023];
  string        exp_req  [0:1023];
  int           wr_i = 0;
  int           rd_i = 0;

  // reference window state
  bit m_pend = 0;
  int m_pos  = 0;

  function automatic logic [47:0] model(input logic [127:0] ln, input bit te);
    logic [47:0] st;
    int k;
    st = '0;
    if (!te) begin
      m_pend = 0;
    end else if (m_pend) begin
      for (int i = 0; i < m_pos; i++) st[3*i +: 3] = 3'b010;
      st[3*m_pos +: 3] = 3'b100;
      m_pend = 0;
    end else begin
      k = -1;
      for (int i = 0; i < 16; i++)
        if (k < 0 && ln[8*i+4 +: 4] == 4'hE) k = i;
      if (k >= 0) begin
        st[3*k +: 3] = 3'b001;
        for (int i = k + 1; i < 16; i++) st[3*i +: 3] = 3'b010;
        m_pend = 1;
        m_pos  = k;
      end
    end
    return st;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] ln, input bit te, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_line  = ln;
    test_en  = te;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_line[wr_i % 1024] = ln;
    exp_stat[wr_i % 1024] = model(ln, te);
    exp_req[wr_i % 1024]  = req;
    wr_i++;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [7:0] filler();
    return {4'h3, 4'($urandom)};
  endfunction

  function automatic logic [7:0] hitbyte();
    return {4'hE, 4'($urandom)};
  endfunction

  function automatic logic [127:0] rand_line(input int pct);
    logic [127:0] l;
    for (int i = 0; i < 16; i++)
      l[8*i +: 8] = (($urandom % 100) < pct) ? hitbyte() : filler();
    return l;
  endfunction

  // downstream ready
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // output monitor, R9 order and data, status per tagged requirement
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (rd_i >= wr_i) begin
          check(1'b0, "R9", "unexpected output", out_line, '0);
        end else begin
          check(out_line == exp_line[rd_i % 1024], "R9", "line",
                out_line, exp_line[rd_i % 1024]);
          check(out_status == exp_stat[rd_i % 1024], exp_req[rd_i % 1024], "status",
                {80'd0, out_status}, {80'd0, exp_stat[rd_i % 1024]});
          rd_i++;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rd_i, wr_i);
    finish_run();
  end

  initial begin
    logic [127:0] l;
    rst_n    = 1'b0;
    test_en  = 1'b0;
    in_valid = 1'b0;
    in_line  = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid", {127'd0, out_valid}, 128'd0);
    check(in_ready == 1'b1, "R1", "in_ready", {127'd0, in_ready}, 128'd1);
    rst_n = 1'b1;

    // R8 one-cycle latency
    send(rand_line(0), 1'b1, "R8");
    idle();
    #2;
    check(out_valid == 1'b1, "R8", "latency", {127'd0, out_valid}, 128'd1);
    repeat (2) @(negedge clk);

    // R4 R5 R7 sweep of branch position with later matches and full-match closing line
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 16; i++)
        l[8*i +: 8] = (i < p) ? filler() : (i == p || (i % 3) == 0) ? hitbyte() : filler();
      send(l, 1'b1, (p == 0 || p == 15) ? "R7" : "R4");
      for (int i = 0; i < 16; i++) l[8*i +: 8] = hitbyte();
      send(l, 1'b1, "R5");
    end
    // R6 line after a closing line carries no target
    send(rand_line(0), 1'b1, "R6");

    // R3 test mode off: match ignored, no window opened
    l = rand_line(50);
    l[7:0] = hitbyte();
    send(l, 1'b0, "R3");
    send(rand_line(0), 1'b1, "R3");
    // R3 window abandoned when test mode drops
    l[7:0] = filler();
    l[47:40] = hitbyte();
    send(l, 1'b1, "R4");
    send(rand_line(30), 1'b0, "R3");
    send(rand_line(0), 1'b1, "R3");
    idle();

    // R8 random stream under backpressure with mode drops
    bp_on = 1;
    for (int n = 0; n < 300; n++)
      send(rand_line(8), (($urandom % 8) != 0), "R6");
    idle();
    bp_on = 0;

    repeat (20) @(negedge clk);
    check(rd_i == wr_i, "R9", "drained", 128'(rd_i), 128'(wr_i));
    finish_run();
  end
endmodule